// File: doc/BRIEF.md
# Divergent-Branch Lane Mask Stack

This block holds the per-lane execution mask of a single wave and keeps it correct while the wave runs divergent control flow. A lane whose mask bit is 0 must not have any register changed by the instruction being issued. The datapath reads `exec_mask` to gate those writes. The block does not execute lane instructions itself.

The block keeps a bounded last-in, first-out stack. Every entry pairs a saved mask with an instruction address at which the wave later resumes. The issue stage presents one mask operation per cycle, and the per-lane condition bits arrive as a vector. The operations are: save the mask, restore the mask, narrow the mask by a condition, and a two-way branch that records both the reconvergence point and a pending else path. When a restore happens, whether requested or automatic, the block drives a one-cycle program-counter override so that the fetch unit jumps to the saved address. If a save finds the stack full, the block raises a sticky overflow error and ignores the operation. If a restore finds the stack empty, it raises a sticky underflow error.

All outputs are registered. An operation accepted at one rising edge is visible on the outputs directly after that edge.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, `exec_mask` is all ones, `pc_valid`, `overflow` and `underflow` are 0, and the stack holds no entries.
- R2: Operation code 0 (save) pushes the pair {current mask, `addr_a`} when the stack has a free slot. It changes neither `exec_mask` nor `pc_valid`.
- R3: Operation code 1 (restore) on a non-empty stack removes the top entry, loads its mask into `exec_mask`, and drives its address on `pc_target` with `pc_valid` high. Entries come back in last-in, first-out order.
- R4: Operation code 2 (narrow) sets `exec_mask` to `exec_mask & cond`. When that result is non-zero, there is no redirect.
- R5: When a narrow operation yields an all-zero mask and the stack is not empty, the block restores the top entry in the same cycle, exactly as in R3.
- R6: Operation code 3 (branch) with lanes on both sides pushes {mask, `addr_a`}, then pushes {mask & ~cond, `addr_b`}, and sets `exec_mask` to mask & cond. Restores therefore return the else entry first.
- R7: A branch in which every active lane has its condition set pushes only {mask, `addr_a`} and sets `exec_mask` to mask & cond.
- R8: A branch in which no active lane has its condition set pushes {mask, `addr_a`}, sets `exec_mask` to mask & ~cond, and redirects to `addr_b` with a one-cycle `pc_valid`.
- R9: A save, or a branch that needs more slots than remain free (2 slots when both sides have lanes, otherwise 1), sets `overflow`, which stays set until reset. The operation is ignored: the mask and the stack are unchanged and there is no redirect.
- R10: A restore on an empty stack sets the sticky `underflow` flag, leaves `exec_mask` unchanged and does not redirect. A narrow operation that reaches zero on an empty stack also sets `underflow` and leaves `exec_mask` all zero.
- R11: `pc_valid` is high for exactly one cycle after each restore, automatic restore or branch fallback, and is low at all other times. A cycle with `op_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 2 | 0 save, 1 restore, 2 narrow, 3 branch |
| cond | input | LANES | Per-lane condition (operand non-zero) |
| addr_a | input | AW | Reconvergence address for save and branch |
| addr_b | input | AW | Else-path address for branch |
| exec_mask | output | LANES | Current per-lane execution mask |
| pc_valid | output | 1 | One-cycle program-counter override strobe |
| pc_target | output | AW | Override address, meaningful while pc_valid is high |
| overflow | output | 1 | Sticky: a save or branch found too few free slots |
| underflow | output | 1 | Sticky: a restore found the stack empty |

## Verification
A corrupted stack entry stays hidden until that entry is restored. At that point it appears as a wrong `exec_mask` or `pc_target` in the cycle right after the restore. A wrong depth count shows up earlier, as a restore that reports underflow too soon, or as a save that is refused or wrongly accepted at the full boundary. For this reason the bench drains the stack after every branch, so that each saved pair is exposed within a few cycles of being written. It sweeps every condition pattern of an 8-lane wave, both from a full mask and from a partial mask.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;

  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_NARROW  = 2'd2,
    OP_BRANCH  = 2'd3
  } mask_op_e;

endpackage

// File: rtl/mask_entry_store.sv
module mask_entry_store #(
  parameter int LANES = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       wr_count,
  input  logic [LANES-1:0] wr0_mask,
  input  logic [AW-1:0]    wr0_addr,
  input  logic [LANES-1:0] wr1_mask,
  input  logic [AW-1:0]    wr1_addr,
  input  logic             rd_pop,
  output logic [LANES-1:0] top_mask,
  output logic [AW-1:0]    top_addr,
  output logic [CW-1:0]    level,
  output logic [CW-1:0]    free_slots
);

  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [LANES-1:0] mask_mem [DEPTH];
  logic [AW-1:0]    addr_mem [DEPTH];

  assign free_slots = CAP - level;

  always_comb begin
    top_mask = '0;
    top_addr = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (level == CW'(i + 1)) begin
        top_mask = mask_mem[i];
        top_addr = addr_mem[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_count != 2'd0 && level == CW'(i)) begin
        mask_mem[i] <= wr0_mask;
        addr_mem[i] <= wr0_addr;
      end
      if (wr_count == 2'd2 && (level + CW'(1)) == CW'(i)) begin
        mask_mem[i] <= wr1_mask;
        addr_mem[i] <= wr1_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
    end else begin
      level <= level + CW'(wr_count) - CW'(rd_pop);
    end
  end

endmodule

// File: rtl/mask_op_logic.sv
module mask_op_logic
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int AW    = 16,
  parameter int CW    = 4
) (
  input  logic             op_valid,
  input  mask_op_e         op,
  input  logic [LANES-1:0] cond,
  input  logic [LANES-1:0] cur_mask,
  input  logic [AW-1:0]    addr_a,
  input  logic [AW-1:0]    addr_b,
  input  logic [CW-1:0]    level,
  input  logic [CW-1:0]    free_slots,
  input  logic [LANES-1:0] top_mask,
  input  logic [AW-1:0]    top_addr,
  output logic [1:0]       wr_count,
  output logic [LANES-1:0] wr0_mask,
  output logic [AW-1:0]    wr0_addr,
  output logic [LANES-1:0] wr1_mask,
  output logic [AW-1:0]    wr1_addr,
  output logic             rd_pop,
  output logic             mask_we,
  output logic [LANES-1:0] mask_d,
  output logic             redirect,
  output logic [AW-1:0]    redirect_addr,
  output logic             ovf_evt,
  output logic             udf_evt
);

  function automatic logic [LANES-1:0] lanes_taken(input logic [LANES-1:0] m,
                                                   input logic [LANES-1:0] c);
    return m & c;
  endfunction

  function automatic logic [LANES-1:0] lanes_else(input logic [LANES-1:0] m,
                                                  input logic [LANES-1:0] c);
    return m & ~c;
  endfunction

  function automatic logic [CW-1:0] slots_needed(input mask_op_e o,
                                                 input logic [LANES-1:0] t,
                                                 input logic [LANES-1:0] e);
    if (o == OP_BRANCH && t != '0 && e != '0) return CW'(2);
    return CW'(1);
  endfunction

  logic [LANES-1:0] taken;
  logic [LANES-1:0] other;
  logic             room;
  logic             empty;

  assign taken = lanes_taken(cur_mask, cond);
  assign other = lanes_else(cur_mask, cond);
  assign room  = free_slots >= slots_needed(op, taken, other);
  assign empty = (level == '0);

  always_comb begin
    wr_count      = 2'd0;
    wr0_mask      = cur_mask;
    wr0_addr      = addr_a;
    wr1_mask      = other;
    wr1_addr      = addr_b;
    rd_pop        = 1'b0;
    mask_we       = 1'b0;
    mask_d        = cur_mask;
    redirect      = 1'b0;
    redirect_addr = top_addr;
    ovf_evt       = 1'b0;
    udf_evt       = 1'b0;
    if (op_valid) begin
      unique case (op)
        OP_SAVE: begin
          if (room) wr_count = 2'd1;
          else      ovf_evt  = 1'b1;
        end
        OP_RESTORE: begin
          if (!empty) begin
            rd_pop   = 1'b1;
            mask_we  = 1'b1;
            mask_d   = top_mask;
            redirect = 1'b1;
          end else begin
            udf_evt = 1'b1;
          end
        end
        OP_NARROW: begin
          mask_we = 1'b1;
          if (taken != '0) begin
            mask_d = taken;
          end else if (!empty) begin
            rd_pop   = 1'b1;
            mask_d   = top_mask;
            redirect = 1'b1;
          end else begin
            udf_evt = 1'b1;
            mask_d  = '0;
          end
        end
        OP_BRANCH: begin
          if (!room) begin
            ovf_evt = 1'b1;
          end else if (taken == '0) begin
            wr_count      = 2'd1;
            mask_we       = 1'b1;
            mask_d        = other;
            redirect      = 1'b1;
            redirect_addr = addr_b;
          end else if (other == '0) begin
            wr_count = 2'd1;
            mask_we  = 1'b1;
            mask_d   = taken;
          end else begin
            wr_count = 2'd2;
            mask_we  = 1'b1;
            mask_d   = taken;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DEPTH = 6,
  parameter int AW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_code,
  input  logic [LANES-1:0] cond,
  input  logic [AW-1:0]    addr_a,
  input  logic [AW-1:0]    addr_b,
  output logic [LANES-1:0] exec_mask,
  output logic             pc_valid,
  output logic [AW-1:0]    pc_target,
  output logic             overflow,
  output logic             underflow
);

  localparam int CW = $clog2(DEPTH + 1) + 1;

  mask_op_e         op;
  logic [1:0]       wr_count;
  logic [LANES-1:0] wr0_mask, wr1_mask, top_mask, mask_d;
  logic [AW-1:0]    wr0_addr, wr1_addr, top_addr, redirect_addr;
  logic [CW-1:0]    level, free_slots;
  logic             rd_pop, mask_we, redirect, ovf_evt, udf_evt;

  assign op = mask_op_e'(op_code);

  mask_entry_store #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_count   (wr_count),
    .wr0_mask   (wr0_mask),
    .wr0_addr   (wr0_addr),
    .wr1_mask   (wr1_mask),
    .wr1_addr   (wr1_addr),
    .rd_pop     (rd_pop),
    .top_mask   (top_mask),
    .top_addr   (top_addr),
    .level      (level),
    .free_slots (free_slots)
  );

  mask_op_logic #(.LANES(LANES), .AW(AW), .CW(CW)) u_ops (
    .op_valid      (op_valid),
    .op            (op),
    .cond          (cond),
    .cur_mask      (exec_mask),
    .addr_a        (addr_a),
    .addr_b        (addr_b),
    .level         (level),
    .free_slots    (free_slots),
    .top_mask      (top_mask),
    .top_addr      (top_addr),
    .wr_count      (wr_count),
    .wr0_mask      (wr0_mask),
    .wr0_addr      (wr0_addr),
    .wr1_mask      (wr1_mask),
    .wr1_addr      (wr1_addr),
    .rd_pop        (rd_pop),
    .mask_we       (mask_we),
    .mask_d        (mask_d),
    .redirect      (redirect),
    .redirect_addr (redirect_addr),
    .ovf_evt       (ovf_evt),
    .udf_evt       (udf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exec_mask <= '1;
      pc_valid  <= 1'b0;
      pc_target <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (mask_we) exec_mask <= mask_d;
      pc_valid <= redirect;
      if (redirect) pc_target <= redirect_addr;
      if (ovf_evt) overflow <= 1'b1;
      if (udf_evt) underflow <= 1'b1;
    end
  end

endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk
  import simt_mask_pkg::*;
#(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [1:0]       op_code,
  input logic [LANES-1:0] cond,
  input logic [LANES-1:0] exec_mask,
  input logic             pc_valid,
  input logic             overflow,
  input logic             underflow,
  input logic             redirect,
  input logic             ovf_evt,
  input logic             udf_evt
);

  assert_save_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SAVE) |=> ($stable(exec_mask) && !pc_valid));

  assert_narrow_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_NARROW && (cond & exec_mask) != '0)
      |=> (((exec_mask & ~$past(exec_mask)) == '0) && !pc_valid));

  assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_overflow_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ($stable(exec_mask) && !pc_valid && overflow));

  assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_empty_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_evt && op_code == OP_RESTORE) |=> ($stable(exec_mask) && !pc_valid));

  assert_redirect_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> pc_valid);

  assert_no_stray_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> !pc_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(exec_mask) && !pc_valid));

endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .cond      (cond),
  .exec_mask (exec_mask),
  .pc_valid  (pc_valid),
  .overflow  (overflow),
  .underflow (underflow),
  .redirect  (redirect),
  .ovf_evt   (ovf_evt),
  .udf_evt   (udf_evt)
);

// File: tb/tb_simt_mask_stack.sv
module tb_simt_mask_stack;

  localparam int L = 8;
  localparam int D = 3;
  localparam int A = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic [1:0]   op_code = 2'd0;
  logic [L-1:0] cond = '0;
  logic [A-1:0] addr_a = '0;
  logic [A-1:0] addr_b = '0;
  logic [L-1:0] exec_mask;
  logic         pc_valid;
  logic [A-1:0] pc_target;
  logic         overflow;
  logic         underflow;

  always #10 clk = ~clk;

  simt_mask_stack #(.LANES(L), .DEPTH(D), .AW(A)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cond(cond), .addr_a(addr_a), .addr_b(addr_b), .exec_mask(exec_mask),
    .pc_valid(pc_valid), .pc_target(pc_target), .overflow(overflow),
    .underflow(underflow)
  );

  logic [L-1:0] m_mask;
  logic [L-1:0] m_sm [D];
  logic [A-1:0] m_sa [D];
  int           m_cnt;
  bit           m_ovf, m_udf, e_pv;
  logic [A-1:0] e_pt;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic m_push(input logic [L-1:0] mk, input logic [A-1:0] ad);
    m_sm[m_cnt] = mk;
    m_sa[m_cnt] = ad;
    m_cnt++;
  endtask

  task automatic m_pop();
    m_cnt--;
    m_mask = m_sm[m_cnt];
    e_pv = 1'b1;
    e_pt = m_sa[m_cnt];
  endtask

  task automatic model(input int op, input logic [L-1:0] c, input logic [A-1:0] a,
                       input logic [A-1:0] b, output string tag);
    logic [L-1:0] t, o;
    int need;
    e_pv = 1'b0;
    t = m_mask & c;
    o = m_mask & ~c;
    case (op)
      0: if (m_cnt < D) begin tag = "R2"; m_push(m_mask, a); end
         else begin tag = "R9"; m_ovf = 1'b1; end
      1: if (m_cnt > 0) begin tag = "R3"; m_pop(); end
         else begin tag = "R10"; m_udf = 1'b1; end
      2: if (t != '0) begin tag = "R4"; m_mask = t; end
         else if (m_cnt > 0) begin tag = "R5"; m_pop(); end
         else begin tag = "R10"; m_udf = 1'b1; m_mask = '0; end
      default: begin
        need = (t != '0 && o != '0) ? 2 : 1;
        if (m_cnt + need > D) begin tag = "R9"; m_ovf = 1'b1; end
        else begin
          m_push(m_mask, a);
          if (t == '0) begin tag = "R8"; m_mask = o; e_pv = 1'b1; e_pt = b; end
          else if (o == '0) begin tag = "R7"; m_mask = t; end
          else begin tag = "R6"; m_push(o, b); m_mask = t; end
        end
      end
    endcase
  endtask

  task automatic compare(input string tag);
    chk(tag, "exec_mask", 32'(exec_mask), 32'(m_mask));
    chk("R11", "pc_valid", 32'(pc_valid), 32'(e_pv));
    if (e_pv) chk(tag, "pc_target", 32'(pc_target), 32'(e_pt));
    chk(tag, "overflow", 32'(overflow), 32'(m_ovf));
    chk(tag, "underflow", 32'(underflow), 32'(m_udf));
  endtask

  task automatic run(input int op, input logic [L-1:0] c,
                     input logic [A-1:0] a, input logic [A-1:0] b);
    string tag;
    op_valid = 1'b1;
    op_code  = 2'(op);
    cond     = c;
    addr_a   = a;
    addr_b   = b;
    model(op, c, a, b, tag);
    @(negedge clk);
    op_valid = 1'b0;
    compare(tag);
  endtask

  task automatic idle();
    op_valid = 1'b0;
    op_code  = 2'd3;
    cond     = '1;
    e_pv     = 1'b0;
    @(negedge clk);
    compare("R11");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_mask = '1;
    m_cnt = 0;
    m_ovf = 1'b0;
    m_udf = 1'b0;
    e_pv = 1'b0;
    e_pt = '0;
    chk("R1", "exec_mask", 32'(exec_mask), 32'hFF);
    chk("R1", "pc_valid", 32'(pc_valid), 32'd0);
    chk("R1", "overflow", 32'(overflow), 32'd0);
    chk("R1", "underflow", 32'(underflow), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    run(1, '0, 8'h00, 8'h00);           // R1 empty stack, R10 underflow
    idle();

    do_reset();
    run(0, '0, 8'h21, 8'h00);           // R2
    run(2, 8'h0F, 8'h00, 8'h00);        // R4
    run(3, 8'h03, 8'h30, 8'h40);        // R6
    run(1, '0, 8'h00, 8'h00);           // R3 else entry
    run(1, '0, 8'h00, 8'h00);           // R3 converge entry
    run(1, '0, 8'h00, 8'h00);           // R3 saved entry
    idle();                             // R11

    do_reset();
    run(0, '0, 8'h01, 8'h00);
    run(0, '0, 8'h02, 8'h00);
    run(0, '0, 8'h03, 8'h00);
    run(0, '0, 8'h04, 8'h00);           // R9 full
    idle();
    run(1, '0, 8'h00, 8'h00);           // R9 stack untouched: top is still 03

    do_reset();
    run(0, '0, 8'h01, 8'h00);
    run(0, '0, 8'h02, 8'h00);
    run(3, 8'h0F, 8'h50, 8'h60);        // R9 needs two slots
    run(3, 8'hFF, 8'h70, 8'h80);        // R9 sticky, R7 fits in one slot

    do_reset();
    run(2, 8'h00, 8'h00, 8'h00);        // R10 narrow to zero on empty

    do_reset();
    for (int c = 0; c < 256; c++) begin
      run(3, 8'(c), 8'(c), ~8'(c));
      while (m_cnt > 0) run(1, '0, 8'h00, 8'h00);
    end
    for (int c = 0; c < 256; c++) begin
      run(0, '0, 8'(c), 8'h00);
      run(2, 8'(c), 8'h00, 8'h00);      // R4 or R5
      if (m_cnt > 0) run(1, '0, 8'h00, 8'h00);
    end
    run(0, '0, 8'h11, 8'h00);
    run(2, 8'hA5, 8'h00, 8'h00);
    for (int c = 0; c < 256; c++) begin
      run(3, 8'(c), 8'(c + 1), 8'(c + 2));
      while (m_cnt > 1) run(1, '0, 8'h00, 8'h00);
    end
    run(1, '0, 8'h00, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule